// File: doc/BRIEF.md
# Sequential Adaptive-Filter Weight Update Engine

This block owns the weight register file of an adaptive FIR filter and applies one least-mean-square correction pass to it on request. A controller delivers a single signed 16-bit step value, which is the filter error already multiplied by the learning rate. The engine then walks an index from 0 to N-1. At each index it selects the tap sample and the stored weight, multiplies the tap by the step, drops the 15 fractional bits of the product, and adds the result to the weight. The sum is clamped to the 16-bit signed range and written back into the same weight.

The whole pass uses one multiplier and one adder. Each clock cycle updates one weight, so a pass takes N cycles. When the last weight has been written, the engine raises a completion token on a small valid/ready output stream. The busy output is high from the cycle after the step value is accepted until the token is consumed. The filter uses it to freeze its delay line, so the tap samples stay constant for the whole pass. The weights are driven out continuously, for the filter's own multiply-accumulate.

Top module: `lms_wupd_engine`

## Requirements
- R1: While reset is active, and right after it, every weight is 0, busy is low, ack_valid is low and upd_ready is high. This also holds when reset arrives in the middle of a pass.
- R2: A step value is accepted on a rising edge where upd_valid and upd_ready are both high. upd_ready is high only while the engine is idle.
- R3: At index i, the new weight equals the old weight plus the 32-bit product tap[i]·step, arithmetically shifted right by 15 (floor division by 32768). The step is two's complement in upd_data[15:0], and tap i is two's complement in taps_flat[16i+15:16i].
- R4: A sum above 32767 is stored as 32767, and a sum below -32768 is stored as -32768. Neither case wraps.
- R5: Weight 0 is written on the first edge after acceptance, weight 1 on the second, and so on in ascending index order. Exactly one weight changes per cycle, and weight N-1 is written on edge N.
- R6: ack_valid rises exactly N edges after the accepting edge. It stays high until a rising edge with ack_ready high.
- R7: busy is high from the edge after acceptance through the edge that consumes the token. After that edge, busy is low and upd_ready is high.
- R8: Once a step value has been accepted, changes on upd_valid or upd_data during the pass have no effect. The pass completes with the step value captured at acceptance.
- R9: While the engine is idle, the weights do not change, whatever taps_flat and upd_data do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | 1 | Step value offered |
| upd_data | input | 16 | Signed error-times-rate step value |
| upd_ready | output | 1 | Engine idle, can take a step value |
| taps_flat | input | N·16 | Tap samples from the filter delay line, lane i at bits 16i+15:16i |
| weights_flat | output | N·16 | Current weights, lane i at bits 16i+15:16i |
| busy | output | 1 | Pass in progress or token pending; the filter freezes its taps while high |
| ack_valid | output | 1 | Completion token present |
| ack_ready | input | 1 | Consumer takes the token |

## Verification
The assertions take for granted that the tap samples stay constant while busy is high. The stimulus therefore changes taps_flat only while the engine is idle. The per-cycle lane check assumes that the weights are written only by this engine, and that reset is the only other way they change. The bench keeps ack_ready low until it has observed the token, so that the hold behaviour of the completion stream is exercised. It also moves upd_valid and upd_data during a pass, to show that the captured step value is the one that is used.

// File: rtl/lms_wupd_pkg.sv
// Shared types for the weight update engine.
// Assumes: nothing beyond IEEE 1800-2017.
package lms_wupd_pkg;

    // Engine sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_ACK  = 2'd2
    } eng_state_t;

endpackage

// File: rtl/lms_wupd_ctrl.sv
// Sequencer: accepts a step value, walks the index across all taps and
// presents a completion token.
// Assumes: N_TAPS >= 2, and IDX_W wide enough to hold N_TAPS-1.
module lms_wupd_ctrl
    import lms_wupd_pkg::*;
#(
    parameter int N_TAPS = 8,
    parameter int IDX_W  = $clog2(N_TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic             ack_ready,
    output logic             upd_ready,
    output logic             ack_valid,
    output logic             busy,
    output logic             wr_en,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_TAPS - 1);

    eng_state_t state_q;

    // Decode the handshake and write strobes from the state
    always_comb begin
        upd_ready = (state_q == ST_IDLE);
        ack_valid = (state_q == ST_ACK);
        busy      = (state_q != ST_IDLE);
        wr_en     = (state_q == ST_RUN);
    end

    // State and index counter advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    idx <= '0;
                    if (upd_valid) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (idx == LAST_IDX) begin
                        state_q <= ST_ACK;
                        idx     <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_ACK: begin
                    if (ack_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lms_wupd_mac.sv
// Shared datapath: selects one tap and one weight, multiplies the tap by
// the step value, drops FRAC fraction bits, adds and clamps.
// Assumes: 0 < FRAC < DW, and the operands are two's complement.
module lms_wupd_mac #(
    parameter int N_TAPS = 8,
    parameter int DW     = 16,
    parameter int FRAC   = 15,
    parameter int IDX_W  = $clog2(N_TAPS)
) (
    input  logic [N_TAPS*DW-1:0] taps_flat,
    input  logic [N_TAPS*DW-1:0] weights_flat,
    input  logic [IDX_W-1:0]     idx,
    input  logic [DW-1:0]        step,
    output logic [DW-1:0]        new_w
);

    localparam int PW    = 2*DW - FRAC;  // width of the shifted product
    localparam int SUM_W = PW + 1;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((2**(DW-1)) - 1);
    localparam logic signed [SUM_W-1:0] LO = -SUM_W'(2**(DW-1));

    logic signed [DW-1:0]    tap_sel;
    logic signed [DW-1:0]    w_sel;
    logic signed [2*DW-1:0]  prod;
    logic signed [PW-1:0]    inc;
    logic signed [SUM_W-1:0] sum;

    // N-to-1 selection of the operands for the current index
    always_comb begin
        tap_sel = '0;
        w_sel   = '0;
        for (int i = 0; i < N_TAPS; i++) begin
            if (idx == IDX_W'(i)) begin
                tap_sel = taps_flat[i*DW +: DW];
                w_sel   = weights_flat[i*DW +: DW];
            end
        end
    end

    // Single multiplier, truncating shift, single adder, clamp
    always_comb begin
        prod = tap_sel * $signed(step);
        inc  = prod[2*DW-1:FRAC];
        sum  = SUM_W'(w_sel) + SUM_W'(inc);
        if (sum > HI)
            new_w = HI[DW-1:0];
        else if (sum < LO)
            new_w = LO[DW-1:0];
        else
            new_w = sum[DW-1:0];
    end

endmodule

// File: rtl/lms_wupd_regfile.sv
// Weight register file with a 1-to-N write demultiplexer.
// Assumes: at most one lane is addressed per cycle, through idx.
module lms_wupd_regfile #(
    parameter int N_TAPS = 8,
    parameter int DW     = 16,
    parameter int IDX_W  = $clog2(N_TAPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     idx,
    input  logic [DW-1:0]        wr_data,
    output logic [N_TAPS*DW-1:0] weights_flat
);

    for (genvar g = 0; g < N_TAPS; g++) begin : g_lane
        // Lane g stores the result only when the index points at it
        always_ff @(posedge clk) begin
            if (!rst_n)
                weights_flat[g*DW +: DW] <= '0;
            else if (wr_en && (idx == IDX_W'(g)))
                weights_flat[g*DW +: DW] <= wr_data;
        end
    end

endmodule

// File: rtl/lms_wupd_engine.sv
// Top: time-multiplexed weight update engine with a step-value input
// stream and a completion-token output stream.
// Assumes: taps_flat stays constant while busy is high.
module lms_wupd_engine #(
    parameter int N_TAPS = 8,
    parameter int DW     = 16,
    parameter int FRAC   = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_valid,
    input  logic [DW-1:0]        upd_data,
    output logic                 upd_ready,
    input  logic [N_TAPS*DW-1:0] taps_flat,
    output logic [N_TAPS*DW-1:0] weights_flat,
    output logic                 busy,
    output logic                 ack_valid,
    input  logic                 ack_ready
);

    localparam int IDX_W = $clog2(N_TAPS);

    logic             wr_en;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    step_q;
    logic [DW-1:0]    new_w;

    // Capture the step value on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_q <= '0;
        else if (upd_valid && upd_ready)
            step_q <= upd_data;
    end

    lms_wupd_ctrl #(.N_TAPS(N_TAPS), .IDX_W(IDX_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .ack_ready (ack_ready),
        .upd_ready (upd_ready),
        .ack_valid (ack_valid),
        .busy      (busy),
        .wr_en     (wr_en),
        .idx       (idx)
    );

    lms_wupd_mac #(.N_TAPS(N_TAPS), .DW(DW), .FRAC(FRAC), .IDX_W(IDX_W)) mac_i (
        .taps_flat    (taps_flat),
        .weights_flat (weights_flat),
        .idx          (idx),
        .step         (step_q),
        .new_w        (new_w)
    );

    lms_wupd_regfile #(.N_TAPS(N_TAPS), .DW(DW), .IDX_W(IDX_W)) rf_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .idx          (idx),
        .wr_data      (new_w),
        .weights_flat (weights_flat)
    );

endmodule

// File: rtl/lms_wupd_chk.sv
// Protocol and sequencing checker for the weight update engine.
// Assumes: only the engine writes the weights.
module lms_wupd_chk #(
    parameter int N_TAPS = 8,
    parameter int DW     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 upd_valid,
    input logic                 upd_ready,
    input logic [N_TAPS*DW-1:0] weights_flat,
    input logic                 busy,
    input logic                 ack_valid,
    input logic                 ack_ready
);

    localparam int CW = $clog2(N_TAPS) + 2;

    logic [N_TAPS*DW-1:0] w_prev;
    logic [N_TAPS-1:0]    lane_chg;
    logic [CW-1:0]        edge_cnt;

    // Remember last cycle's weights
    always_ff @(posedge clk) begin
        if (!rst_n) w_prev <= '0;
        else        w_prev <= weights_flat;
    end

    for (genvar g = 0; g < N_TAPS; g++) begin : g_chg
        assign lane_chg[g] = (weights_flat[g*DW +: DW] != w_prev[g*DW +: DW]);
    end

    // Count edges since acceptance, stopping once the token shows
    always_ff @(posedge clk) begin
        if (!rst_n)
            edge_cnt <= '0;
        else if (upd_valid && upd_ready)
            edge_cnt <= '0;
        else if (busy && !ack_valid)
            edge_cnt <= edge_cnt + 1'b1;
    end

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_ready) |=> (busy && !upd_ready));

    p_one_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lane_chg) <= 1);

    p_ack_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_valid) |-> (edge_cnt == CW'(N_TAPS)));

    p_ack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ack_ready) |=> ack_valid);

    p_ack_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_ready) |=> (!busy && upd_ready));

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(weights_flat));

endmodule

bind lms_wupd_engine lms_wupd_chk #(.N_TAPS(N_TAPS), .DW(DW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_valid    (upd_valid),
    .upd_ready    (upd_ready),
    .weights_flat (weights_flat),
    .busy         (busy),
    .ack_valid    (ack_valid),
    .ack_ready    (ack_ready)
);

// File: tb/lms_wupd_engine_tb_top.sv
// Self-checking bench for the weight update engine.
module lms_wupd_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int DW = 16;
    localparam int NVEC = 6;
    localparam int VEC_GAIN [NVEC] = '{16384, -20000, 32767, -32768, 100, -1};
    localparam int VEC_SEED [NVEC] = '{1234, 777, -3000, 5555, -32768, 32767};

    logic            clk = 1'b0;
    logic            rst_n;
    logic            upd_valid;
    logic [DW-1:0]   upd_data;
    logic            upd_ready;
    logic [N*DW-1:0] taps_flat;
    logic [N*DW-1:0] weights_flat;
    logic            busy;
    logic            ack_valid;
    logic            ack_ready;

    int errs   = 0;
    int checks = 0;
    int model_w [N];
    int tap_v   [N];

    lms_wupd_engine #(.N_TAPS(N), .DW(DW), .FRAC(15)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .upd_valid    (upd_valid),
        .upd_data     (upd_data),
        .upd_ready    (upd_ready),
        .taps_flat    (taps_flat),
        .weights_flat (weights_flat),
        .busy         (busy),
        .ack_valid    (ack_valid),
        .ack_ready    (ack_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lane(input int i);
        logic signed [DW-1:0] v;
        v = weights_flat[i*DW +: DW];
        return int'(v);
    endfunction

    function automatic int s16(input int x);
        logic signed [DW-1:0] v;
        v = DW'(x);
        return int'(v);
    endfunction

    task automatic drive_taps();
        for (int i = 0; i < N; i++) taps_flat[i*DW +: DW] = DW'(tap_v[i]);
    endtask

    // Reference rule: add floor(tap*step/2^15), then clamp to 16 bits
    function automatic int next_w(input int w, input int t, input int g);
        int p, s;
        p = t * g;
        s = w + (p >>> 15);
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    task automatic run_update(input int gain, input bit poke);
        int nw [N];
        for (int i = 0; i < N; i++) nw[i] = next_w(model_w[i], tap_v[i], gain);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_data  = DW'(gain);
        chk(upd_ready == 1'b1, "R2 ready before accept", int'(upd_ready), 1);
        @(posedge clk);
        @(negedge clk);
        upd_valid = poke;
        if (poke) upd_data = ~upd_data;
        chk(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
        chk(upd_ready == 1'b0, "R2 ready low in pass", int'(upd_ready), 0);
        for (int k = 1; k <= N; k++) begin
            @(posedge clk);
            @(negedge clk);
            for (int j = 0; j < N; j++) begin
                int e;
                e = (j < k) ? nw[j] : model_w[j];
                chk(lane(j) == e, (poke ? "R8 step held, R3/R5 lane" : "R3/R5 lane order"),
                    lane(j), e);
            end
            chk(ack_valid == (k == N), "R6 ack latency", int'(ack_valid), int'(k == N));
            if (poke) chk(upd_ready == 1'b0, "R8 ignored while busy", int'(upd_ready), 0);
        end
        upd_valid = 1'b0;
        repeat (2) begin
            @(posedge clk);
            @(negedge clk);
            chk(ack_valid == 1'b1, "R6 ack held", int'(ack_valid), 1);
            chk(busy == 1'b1, "R7 busy until ack", int'(busy), 1);
        end
        ack_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack_ready = 1'b0;
        chk(busy == 1'b0, "R7 busy cleared", int'(busy), 0);
        chk(ack_valid == 1'b0, "R6 ack consumed", int'(ack_valid), 0);
        chk(upd_ready == 1'b1, "R7 idle ready", int'(upd_ready), 1);
        for (int i = 0; i < N; i++) model_w[i] = nw[i];
    endtask

    task automatic check_reset_state();
        for (int i = 0; i < N; i++) begin
            chk(lane(i) == 0, "R1 weight zero", lane(i), 0);
            model_w[i] = 0;
        end
        chk(busy == 1'b0, "R1 busy low", int'(busy), 0);
        chk(ack_valid == 1'b0, "R1 ack low", int'(ack_valid), 0);
        chk(upd_ready == 1'b1, "R1 ready high", int'(upd_ready), 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        upd_valid = 1'b0;
        ack_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_reset_state();
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        upd_valid = 1'b0;
        upd_data  = '0;
        ack_ready = 1'b0;
        for (int i = 0; i < N; i++) tap_v[i] = 0;
        drive_taps();
        do_reset();

        // Table walk: several tap patterns and step values
        for (int v = 0; v < NVEC; v++) begin
            for (int i = 0; i < N; i++)
                tap_v[i] = s16(VEC_SEED[v] * (2*i + 1) + i * 4099);
            drive_taps();
            run_update(VEC_GAIN[v], v[0]);
        end

        // Idle: weights untouched by tap and data movement (R9)
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) tap_v[i] = s16(c * 9001 + i);
            drive_taps();
            upd_data = DW'(c * 12345);
        end
        @(negedge clk);
        for (int i = 0; i < N; i++)
            chk(lane(i) == model_w[i], "R9 idle hold", lane(i), model_w[i]);

        // Reset in the middle of a pass (R1)
        @(negedge clk);
        upd_valid = 1'b1;
        upd_data  = DW'(20000);
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0;
        repeat (3) @(negedge clk);
        do_reset();

        // Positive clamp: 32767*32767 adds 32766 per pass (R4)
        for (int i = 0; i < N; i++) tap_v[i] = 32767;
        drive_taps();
        repeat (2) run_update(32767, 1'b0);
        for (int i = 0; i < N; i++)
            chk(lane(i) == 32767, "R4 clamp high", lane(i), 32767);

        // Negative clamp: -32768*32767 adds -32767 per pass (R4)
        for (int i = 0; i < N; i++) tap_v[i] = -32768;
        drive_taps();
        repeat (3) run_update(32767, 1'b0);
        for (int i = 0; i < N; i++)
            chk(lane(i) == -32768, "R4 clamp low", lane(i), -32768);

        // Extreme product -32768*-32768 adds +32768 (R3)
        run_update(-32768, 1'b0);
        for (int i = 0; i < N; i++)
            chk(lane(i) == 0, "R3 extreme product", lane(i), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule